// File: doc/BRIEF.md
# Grouped Interrupt Priority Resolver

This block decides which pending interrupt source, if any, the core should take next. Each source carries an 8-bit priority byte in which a smaller number means more urgent. Each source also has an enable bit. A programmable split point divides every priority byte into a preemption field in the upper bits and a sub-priority field in the lower bits. Only the upper bits of each byte are stored. The lower bits always read back as zero.

Each cycle the block selects the best candidate among sources that are both pending and enabled. It compares the full stored byte first and breaks exact ties by taking the lowest source number. It then decides whether that candidate may interrupt the exception currently running. Only the preemption field takes part in that decision. The sub-priority only orders candidates that share a preemption level. The take request, the winning source number and the winner's preemption level come out of one output register.

Configuration uses a plain single-cycle write port. A combinational read port returns the stored priority byte of any source. All control pins are plain levels, with no handshake.

Top module: `irq_prio_resolver`

## Requirements
- R1: A priority write stores only the upper IMPL_BITS (default 4) bits of the byte. The remaining low bits read back as zero on `rd_prio_o`, whatever value was written to them. After reset every priority byte reads as 0x00.
- R2: Among sources that are both pending and enabled, the one with the numerically smallest stored priority byte is the winner.
- R3: The grouping value S (3 bits, reset 0) sets the split point. The preemption field is the stored byte ANDed with `8'hFF << S`, and the lower S bits form the sub-priority. `win_level_o` reports the winner's preemption field. Any S of IMPL_BITS-complement or less (0..4 by default) leaves no sub-priority bits.
- R4: When `act_valid_i` is high, a take occurs only if the winner's preemption field is strictly smaller than `act_prio_i` ANDed with the same mask. An equal or larger value gives no take.
- R5: The sub-priority never enables preemption. If the winner has the same preemption field as the active exception, no take occurs, even when its sub-priority is smaller. Between candidates that share a preemption level, the smaller sub-priority wins.
- R6: When two candidates have identical stored bytes, the lower source number wins.
- R7: When `act_valid_i` is low, any enabled pending source produces a take.
- R8: A pending source whose enable is clear is never selected. All enables are clear after reset. An enable write sets the enable when any bit of `cfg_wdata` is 1 and clears it otherwise.
- R9: Outputs are registered. They reflect the pend and active inputs present at the previous rising edge. A configuration write at an edge first affects the result computed at the following edge.
- R10: When there is no take, `win_id_o` and `win_level_o` are both zero.
- R11: Write encoding on `cfg_kind`: 0 writes the priority of source `cfg_idx`, 1 writes the enable of source `cfg_idx`, 2 writes the grouping value from `cfg_wdata[2:0]`, and 3 does nothing.

Write port use and the behaviour these requirements cover are shown at the ports below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target selector (R11) |
| cfg_idx | input | SRC_W | Source addressed by a priority or enable write |
| cfg_wdata | input | 8 | Write data |
| rd_idx | input | SRC_W | Source whose priority byte is read |
| rd_prio_o | output | 8 | Stored priority byte of `rd_idx`, with the low bits zero |
| pend_i | input | NUM_SRC | Pending flag per source |
| act_valid_i | input | 1 | An exception is currently active |
| act_prio_i | input | 8 | Priority byte of the active exception |
| take_o | output | 1 | The winner should be taken now |
| win_id_o | output | SRC_W | Winning source number |
| win_level_o | output | 8 | Preemption field of the winner |

## Verification
A corrupted enable or priority register shows up on the next registered result as the wrong source number. It can also show up as a take that should not occur or a missing take, because selection reads those registers directly. Stored low bits that leak through appear at once on `rd_prio_o`, and as nonzero low bits in `win_level_o` one edge later. A wrong grouping value is only visible when the active level is close to the winner's level. The nesting cases therefore place the two one sub-priority step apart and check the take decision on the following edge.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int BYTE_W = 8;
  localparam int GRP_W  = 3;

  typedef enum logic [1:0] {
    WR_PRIO  = 2'd0,
    WR_EN    = 2'd1,
    WR_GROUP = 2'd2,
    WR_NONE  = 2'd3
  } wr_kind_e;

  function automatic logic [BYTE_W-1:0] preempt_mask(input logic [GRP_W-1:0] split);
    return 8'hFF << split;
  endfunction
endpackage

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_res_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int IMPL_BITS = 4,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int LOW_W    = BYTE_W - IMPL_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_kind,
  input  logic [SRC_W-1:0]          cfg_idx,
  input  logic [BYTE_W-1:0]         cfg_wdata,
  input  logic [SRC_W-1:0]          rd_idx,
  output logic [BYTE_W-1:0]         rd_prio,
  output logic [NUM_SRC*BYTE_W-1:0] prio_flat,
  output logic [NUM_SRC-1:0]        en_vec,
  output logic [GRP_W-1:0]          grp
);
  logic [IMPL_BITS-1:0] hi_q [NUM_SRC];
  logic [GRP_W-1:0]     grp_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic sel;
    assign sel = cfg_we && (cfg_idx == SRC_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[s]   <= '0;
        en_vec[s] <= 1'b0;
      end else if (sel) begin
        if (cfg_kind == WR_PRIO) hi_q[s]   <= cfg_wdata[BYTE_W-1 -: IMPL_BITS];
        if (cfg_kind == WR_EN)   en_vec[s] <= |cfg_wdata;
      end
    end

    assign prio_flat[s*BYTE_W +: BYTE_W] = {hi_q[s], {LOW_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               grp_q <= '0;
    else if (cfg_we && cfg_kind == WR_GROUP)  grp_q <= cfg_wdata[GRP_W-1:0];
  end

  assign grp     = grp_q;
  assign rd_prio = {hi_q[rd_idx], {LOW_W{1'b0}}};
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_res_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        cand,
  input  logic [NUM_SRC*BYTE_W-1:0] prio_flat,
  output logic                      any,
  output logic [SRC_W-1:0]          best_id,
  output logic [BYTE_W-1:0]         best_prio
);
  // Ascending scan, replace only on strictly smaller: lowest index keeps ties.
  always_comb begin
    any       = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!any || prio_flat[i*BYTE_W +: BYTE_W] < best_prio)) begin
        any       = 1'b1;
        best_id   = SRC_W'(i);
        best_prio = prio_flat[i*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/irq_preempt_gate.sv
module irq_preempt_gate
  import irq_res_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any,
  input  logic [SRC_W-1:0]  best_id,
  input  logic [BYTE_W-1:0] best_prio,
  input  logic              act_valid,
  input  logic [BYTE_W-1:0] act_prio,
  input  logic [GRP_W-1:0]  grp,
  output logic              take,
  output logic [SRC_W-1:0]  win_id,
  output logic [BYTE_W-1:0] win_level
);
  logic [BYTE_W-1:0] mask, cand_lvl, act_lvl;
  logic              take_d;

  always_comb begin
    mask     = preempt_mask(grp);
    cand_lvl = best_prio & mask;
    act_lvl  = act_prio & mask;
    take_d   = any && (!act_valid || (cand_lvl < act_lvl));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take      <= 1'b0;
      win_id    <= '0;
      win_level <= '0;
    end else begin
      take      <= take_d;
      win_id    <= take_d ? best_id  : '0;
      win_level <= take_d ? cand_lvl : '0;
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_res_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int IMPL_BITS = 4,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_kind,
  input  logic [SRC_W-1:0]   cfg_idx,
  input  logic [7:0]         cfg_wdata,
  input  logic [SRC_W-1:0]   rd_idx,
  output logic [7:0]         rd_prio_o,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic               act_valid_i,
  input  logic [7:0]         act_prio_i,
  output logic               take_o,
  output logic [SRC_W-1:0]   win_id_o,
  output logic [7:0]         win_level_o
);
  logic [NUM_SRC*BYTE_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]        en_vec;
  logic [GRP_W-1:0]          grp_w;
  logic                      any;
  logic [SRC_W-1:0]          best_id;
  logic [BYTE_W-1:0]         best_prio;

  irq_prio_bank #(.NUM_SRC(NUM_SRC), .IMPL_BITS(IMPL_BITS)) bank_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .rd_idx(rd_idx),
    .rd_prio(rd_prio_o), .prio_flat(prio_flat), .en_vec(en_vec), .grp(grp_w)
  );

  irq_prio_select #(.NUM_SRC(NUM_SRC)) sel_i (
    .cand(pend_i & en_vec), .prio_flat(prio_flat),
    .any(any), .best_id(best_id), .best_prio(best_prio)
  );

  irq_preempt_gate #(.NUM_SRC(NUM_SRC)) gate_i (
    .clk(clk), .rst_n(rst_n), .any(any), .best_id(best_id),
    .best_prio(best_prio), .act_valid(act_valid_i), .act_prio(act_prio_i),
    .grp(grp_w), .take(take_o), .win_id(win_id_o), .win_level(win_level_o)
  );
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk
  import irq_res_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int IMPL_BITS = 4,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam logic [7:0] LOW_MASK = 8'hFF >> IMPL_BITS
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] pend_i,
  input logic               act_valid_i,
  input logic [7:0]         act_prio_i,
  input logic [GRP_W-1:0]   grp_w,
  input logic [7:0]         rd_prio_o,
  input logic               take_o,
  input logic [SRC_W-1:0]   win_id_o,
  input logic [7:0]         win_level_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic               actv_q;
  logic [7:0]         actp_q;
  logic [GRP_W-1:0]   grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0; actv_q <= 1'b0; actp_q <= '0; grp_q <= '0;
    end else begin
      pend_q <= pend_i; actv_q <= act_valid_i; actp_q <= act_prio_i; grp_q <= grp_w;
    end
  end

  // R8/R9: a take names a source that was pending one edge earlier
  p_take_was_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> pend_q[win_id_o]);

  // R7: nothing pending means nothing taken
  p_no_pend_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !take_o);

  // R4: a take under an active exception is strictly more urgent
  p_strict_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && actv_q) |-> (win_level_o < (actp_q & preempt_mask(grp_q))));

  // R10: idle outputs are zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (win_id_o == '0 && win_level_o == '0));

  // R1: unimplemented low bits never appear
  p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_prio_o & LOW_MASK) == '0) && ((win_level_o & LOW_MASK) == '0));

  // R3: reported level carries no sub-priority bits
  p_level_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((win_level_o & ~preempt_mask(grp_q)) == '0));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.NUM_SRC(NUM_SRC), .IMPL_BITS(IMPL_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .act_valid_i(act_valid_i),
  .act_prio_i(act_prio_i), .grp_w(grp_w), .rd_prio_o(rd_prio_o),
  .take_o(take_o), .win_id_o(win_id_o), .win_level_o(win_level_o)
);

// File: tb/irq_prio_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_prio_resolver_tb_top;
  localparam int NUM_SRC = 8;
  localparam int SRC_W   = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cfg_we = 1'b0;
  logic [1:0]         cfg_kind = '0;
  logic [SRC_W-1:0]   cfg_idx = '0;
  logic [7:0]         cfg_wdata = '0;
  logic [SRC_W-1:0]   rd_idx = '0;
  logic [7:0]         rd_prio_o;
  logic [NUM_SRC-1:0] pend_i = '0;
  logic               act_valid_i = 1'b0;
  logic [7:0]         act_prio_i = '0;
  logic               take_o;
  logic [SRC_W-1:0]   win_id_o;
  logic [7:0]         win_level_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_prio_resolver #(.NUM_SRC(NUM_SRC), .IMPL_BITS(4)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Check take, id and level together
  task automatic chk_out(input string req, input bit t, input int id, input int lvl);
    chk({req, " take"}, int'(take_o), int'(t));
    chk({req, " id"}, int'(win_id_o), id);
    chk({req, " level"}, int'(win_level_o), lvl);
  endtask

  task automatic wr(input logic [1:0] k, input int idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_idx = SRC_W'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive inputs at a falling edge; outputs are valid at the next falling edge
  task automatic apply(input logic [NUM_SRC-1:0] p, input bit av, input logic [7:0] ap);
    @(negedge clk);
    pend_i = p; act_valid_i = av; act_prio_i = ap;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd_idx = 3'd0; #1;
    chk("R1 reset prio", int'(rd_prio_o), 0);
    chk_out("R10 reset", 1'b0, 0, 0);
  endtask

  task automatic t_regs;
    wr(2'd0, 2, 8'hA7);
    rd_idx = 3'd2; #1;
    chk("R1 low bits dropped", int'(rd_prio_o), 'hA0);
    wr(2'd0, 2, 8'h0F);
    #1;
    chk("R1 low-only write", int'(rd_prio_o), 'h00);
    wr(2'd3, 2, 8'hC0);
    #1;
    chk("R11 kind 3 no effect", int'(rd_prio_o), 'h00);
  endtask

  task automatic t_disabled;
    apply(8'hFF, 1'b0, 8'h00);
    chk_out("R8 all disabled", 1'b0, 0, 0);
    wr(2'd1, 5, 8'h10);
    apply(8'hFF, 1'b0, 8'h00);
    chk_out("R8 one enabled", 1'b1, 5, 0);
    wr(2'd1, 5, 8'h00);
    apply(8'hFF, 1'b0, 8'h00);
    chk_out("R8 re-disabled", 1'b0, 0, 0);
  endtask

  task automatic t_order;
    wr(2'd0, 0, 8'h90); wr(2'd0, 1, 8'h30);
    wr(2'd0, 2, 8'h50); wr(2'd0, 3, 8'h30);
    for (int s = 4; s < NUM_SRC; s++) wr(2'd0, s, 8'hF0);
    for (int s = 0; s < NUM_SRC; s++) wr(2'd1, s, 8'h01);
    apply(8'h0F, 1'b0, 8'h00);
    chk_out("R6 tie lowest index", 1'b1, 1, 'h30);
    apply(8'h05, 1'b0, 8'h00);
    chk_out("R2 smallest byte", 1'b1, 2, 'h50);
    apply(8'h80, 1'b0, 8'h00);
    chk_out("R7 lowest urgency taken", 1'b1, 7, 'hF0);
  endtask

  task automatic t_nest;
    apply(8'h04, 1'b1, 8'h60);
    chk_out("R4 more urgent preempts", 1'b1, 2, 'h50);
    apply(8'h04, 1'b1, 8'h50);
    chk_out("R4 equal no preempt", 1'b0, 0, 0);
    apply(8'h04, 1'b1, 8'h40);
    chk_out("R4 less urgent no preempt", 1'b0, 0, 0);
  endtask

  task automatic t_group;
    wr(2'd0, 4, 8'h70); wr(2'd0, 6, 8'h40);
    wr(2'd2, 0, 8'h06);
    apply(8'h10, 1'b0, 8'h00);
    chk_out("R3 level masked", 1'b1, 4, 'h40);
    apply(8'h50, 1'b0, 8'h00);
    chk_out("R5 sub-priority orders", 1'b1, 6, 'h40);
    apply(8'h50, 1'b1, 8'h60);
    chk_out("R5 same group no preempt", 1'b0, 0, 0);
    apply(8'h50, 1'b1, 8'h80);
    chk_out("R3 group preempts", 1'b1, 6, 'h40);
    wr(2'd2, 0, 8'h00);
    apply(8'h10, 1'b0, 8'h00);
    chk_out("R3 no sub bits", 1'b1, 4, 'h70);
  endtask

  task automatic t_latency;
    apply(8'h02, 1'b0, 8'h00);
    chk_out("R9 settle", 1'b1, 1, 'h30);
    pend_i = 8'h00; #1;
    chk("R9 holds until edge", int'(take_o), 1);
    @(negedge clk);
    chk("R9 updates after edge", int'(take_o), 0);
    pend_i = 8'h02;
    cfg_we = 1'b1; cfg_kind = 2'd1; cfg_idx = 3'd1; cfg_wdata = 8'h00;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R9 write not yet seen", int'(take_o), 1);
    @(negedge clk);
    chk("R9 write seen next edge", int'(take_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_order();
    t_nest();
    t_group();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule